// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block compares the running calendar time against a set of stored alarm fields: seconds, minutes, hours, day of month and month. It samples the comparison once per one-second strobe. When the comparison hits while the alarm is armed, a sticky alarm flag is raised. An interrupt output follows that flag, subject to the arming conditions and an output-select bit.

Each alarm field is a BCD byte. Setting its most significant bit turns the field into a don't-care. Only the low bits that a BCD value of that field can occupy take part in the comparison.

Software reaches the block through a byte-wide register port with a synchronous write strobe and a combinational read. The alarm fields sit at addresses 0x9 (seconds), 0xA (minutes), 0xB (hours), 0xC (date) and 0xD (month). The control byte is at 0x0 and the output-select byte is at 0xE. The live time comes from an external calendar counter as five packed bytes.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset, every alarm field reads 0x80, the control byte at 0x0 reads 0x00, the byte at 0xE reads 0x00, and `alarm_irq` is 0.
- R2: A write to 0x9..0xD stores the whole byte, which reads back unchanged. At 0xE only bit 7 is kept. At 0x0 only bit 3 (enable) and bit 2 (calibration mode) are stored. Any other address reads 0x00.
- R3: A field whose stored bit 7 is 1 is left out of the comparison whatever its other bits hold. On a tick, the hit requires every remaining field to equal its live byte.
- R4: The comparison uses bits 6:0 of seconds and minutes, bits 5:0 of hours and date, and bits 4:0 of month. Live bits above those widths have no effect.
- R5: With all five fields marked don't-care, every armed tick sets the flag.
- R6: Without a tick, a matching time never sets the flag.
- R7: The alarm is armed only while enable (control bit 3) is 1 and calibration mode (control bit 2) is 0. An unarmed tick leaves the flag clear.
- R8: The flag, read at control bit 6, stays set until software writes the control byte with bit 6 equal to 0. A write with bit 6 equal to 1 leaves the flag as it was.
- R9: When an armed hit and a flag-clearing write fall in the same cycle, the flag ends up set.
- R10: `alarm_irq` is 1 exactly when the flag is set, the alarm is armed, and bit 7 of the byte at 0xE is 1.
- R11: The flag and `alarm_irq` change at the clock edge that samples the tick. They are visible in the cycle after the tick cycle, not during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle one-second strobe |
| live_time | input | 40 | Live BCD bytes: seconds [7:0], minutes [15:8], hours [23:16], date [31:24], month [39:32] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| alarm_irq | output | 1 | Alarm interrupt output |

## Verification
Register writes and the alarm flag are registered. Their effect shows one clock edge after the strobe cycle. The read port and `alarm_irq` are combinational from that state, so they show the effect in the same cycle the state changes.

The bench drives every strobe for a single cycle from a falling edge. It then samples at the following falling edge, which falls after exactly one rising edge. For the timing requirement it also samples once before that edge, to confirm the flag has not moved early. Expected hit results in the mask sweep come from the mask pattern and the position of the deliberately differing field.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int BYTE_W    = 8;
    localparam int FIELD_CNT = 5;

    localparam logic [3:0] CTRL_ADDR = 4'h0;
    localparam logic [3:0] ALM_BASE  = 4'h9;
    localparam logic [3:0] OSEL_ADDR = 4'hE;

    localparam int DONTCARE_BIT = 7;
    localparam int FLAG_BIT     = 6;
    localparam int EN_BIT       = 3;
    localparam int CAL_BIT      = 2;
    localparam int OSEL_BIT     = 7;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4
    } field_e;

    typedef struct packed {
        logic en;
        logic cal;
    } alarm_ctrl_t;

    function automatic logic [BYTE_W-1:0] field_mask(input int idx);
        case (field_e'(idx[2:0]))
            FLD_SEC, FLD_MIN:   return 8'h7F;
            FLD_HOUR, FLD_DATE: return 8'h3F;
            default:            return 8'h1F;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_byte(input logic flag, input alarm_ctrl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[FLAG_BIT] = flag;
        b[EN_BIT]   = c.en;
        b[CAL_BIT]  = c.cal;
        return b;
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int N_FIELDS = FIELD_CNT
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic                         flag_q,
    output logic [BYTE_W-1:0]            rd_data,
    output logic [N_FIELDS*BYTE_W-1:0]   alm_flat,
    output alarm_ctrl_t                  ctrl_q,
    output logic                         osel_q,
    output logic                         clr_req
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] OSEL_A = ADDR_W'(OSEL_ADDR);
    localparam logic [BYTE_W-1:0] RST_FIELD = BYTE_W'(1) << DONTCARE_BIT;

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == CTRL_A);
    assign clr_req = ctrl_wr && !wr_data[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            osel_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.en  <= wr_data[EN_BIT];
                ctrl_q.cal <= wr_data[CAL_BIT];
            end
            if (wr_en && (wr_addr == OSEL_A))
                osel_q <= wr_data[OSEL_BIT];
        end
    end

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ALM_BASE + g);
        logic [BYTE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= RST_FIELD;
            else if (wr_en && (wr_addr == MY_ADDR))
                q <= wr_data;
        end

        assign alm_flat[g*BYTE_W +: BYTE_W] = q;

        // R2
        alm_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_addr == MY_ADDR)) |=> (q == $past(wr_data)));
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_A)
            rd_data = ctrl_byte(flag_q, ctrl_q);
        else if (rd_addr == OSEL_A)
            rd_data[OSEL_BIT] = osel_q;
        for (int i = 0; i < N_FIELDS; i++) begin
            if (rd_addr == ADDR_W'(ALM_BASE + i))
                rd_data = alm_flat[i*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int N_FIELDS = FIELD_CNT
) (
    input  logic [N_FIELDS*BYTE_W-1:0] alm_flat,
    input  logic [N_FIELDS*BYTE_W-1:0] live_flat,
    output logic                       hit
);

    logic [N_FIELDS-1:0] field_ok;

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_cmp
        localparam logic [BYTE_W-1:0] MASK = field_mask(g);
        logic [BYTE_W-1:0] alm_b;
        logic [BYTE_W-1:0] live_b;
        logic              same;

        assign alm_b    = alm_flat[g*BYTE_W +: BYTE_W];
        assign live_b   = live_flat[g*BYTE_W +: BYTE_W];
        assign same     = ((alm_b ^ live_b) & MASK) == '0;
        assign field_ok[g] = alm_b[DONTCARE_BIT] | same;
    end

    assign hit = &field_ok;

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic armed,
    input  logic hit,
    input  logic clr_req,
    output logic flag_q
);

    logic set_ev;
    assign set_ev = tick & armed & hit;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= (flag_q & ~clr_req) | set_ev;
    end

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_req) |=> flag_q);

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && armed && hit) |=> flag_q);

    // R7
    flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !(tick && armed)) |=> !flag_q);

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int N_FIELDS = FIELD_CNT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic [N_FIELDS*BYTE_W-1:0] live_time,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic                       alarm_irq
);

    logic [N_FIELDS*BYTE_W-1:0] alm_flat;
    alarm_ctrl_t                ctrl_q;
    logic                       osel_q;
    logic                       clr_req;
    logic                       flag_q;
    logic                       hit;
    logic                       armed;

    rtc_alarm_regs #(.ADDR_W(ADDR_W), .N_FIELDS(N_FIELDS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .flag_q   (flag_q),
        .rd_data  (rd_data),
        .alm_flat (alm_flat),
        .ctrl_q   (ctrl_q),
        .osel_q   (osel_q),
        .clr_req  (clr_req)
    );

    rtc_alarm_match #(.N_FIELDS(N_FIELDS)) u_match (
        .alm_flat  (alm_flat),
        .live_flat (live_time),
        .hit       (hit)
    );

    assign armed = ctrl_q.en & ~ctrl_q.cal;

    rtc_alarm_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .armed   (armed),
        .hit     (hit),
        .clr_req (clr_req),
        .flag_q  (flag_q)
    );

    assign alarm_irq = flag_q & armed & osel_q;

    // R10
    irq_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && armed && hit && osel_q && !wr_en) |=> alarm_irq);

endmodule

// File: tb/rtc_alarm_cmp_bench.sv
module rtc_alarm_cmp_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [39:0] live_time = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        alarm_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    rtc_alarm_cmp u_rtc_alarm_cmp (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .live_time (live_time),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .alarm_irq (alarm_irq)
    );

    localparam logic [7:0] BASE [5] = '{8'h45, 8'h37, 8'h21, 8'h28, 8'h11};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load_alarm(input logic [39:0] v);
        for (int i = 0; i < 5; i++) wr(4'h9 + 4'(i), v[i*8 +: 8]);
    endtask

    function automatic logic [39:0] base_time();
        logic [39:0] t;
        for (int i = 0; i < 5; i++) t[i*8 +: 8] = BASE[i];
        return t;
    endfunction

    task automatic flag_now(output logic f);
        logic [7:0] c;
        rd(4'h0, c);
        f = c[6];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic        f;
        logic [39:0] av;
        logic [39:0] lv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            rd(4'h9 + 4'(i), d); check("R1 field reset", d, 8'h80);
        end
        rd(4'h0, d); check("R1 ctrl reset", d, 8'h00);
        rd(4'hE, d); check("R1 osel reset", d, 8'h00);
        check("R1 irq reset", {7'b0, alarm_irq}, 8'h00);

        // R2 register access
        wr(4'hB, 8'hA5); rd(4'hB, d); check("R2 field readback", d, 8'hA5);
        wr(4'hE, 8'hFF); rd(4'hE, d); check("R2 osel keeps bit7", d, 8'h80);
        wr(4'hE, 8'h7F); rd(4'hE, d); check("R2 osel clear", d, 8'h00);
        wr(4'h0, 8'hFF); rd(4'h0, d); check("R2 ctrl bits", d, 8'h0C);
        rd(4'h5, d); check("R2 unmapped", d, 8'h00);

        // R3 / R5 sweep over mask patterns and differing field
        for (int m = 0; m < 32; m++) begin
            for (int dd = 0; dd < 6; dd++) begin
                wr(4'h0, 8'h08);
                av = base_time();
                for (int i = 0; i < 5; i++)
                    if (m[i]) av[i*8 +: 8] = 8'h80 | (BASE[i] ^ 8'h0F);
                load_alarm(av);
                lv = base_time();
                if (dd < 5) lv[dd*8 +: 8] = BASE[dd] ^ 8'h01;
                live_time = lv;
                pulse_tick();
                flag_now(f);
                if (m == 31)
                    check("R5 all masked", {7'b0, f}, 8'h01);
                else
                    check("R3 masked match", {7'b0, f}, {7'b0, (dd == 5) || m[dd % 5]});
            end
        end

        // R4 bits above compare width ignored
        wr(4'h0, 8'h08);
        load_alarm(base_time());
        lv = base_time();
        lv[7:0] |= 8'h80; lv[15:8] |= 8'h80; lv[23:16] |= 8'hC0;
        lv[31:24] |= 8'hC0; lv[39:32] |= 8'hE0;
        live_time = lv;
        pulse_tick(); flag_now(f);
        check("R4 high bits ignored", {7'b0, f}, 8'h01);
        wr(4'h0, 8'h08);
        lv = base_time(); lv[23:16] = BASE[2] ^ 8'h20; lv[39:32] = BASE[4] ^ 8'h10;
        live_time = lv;
        pulse_tick(); flag_now(f);
        check("R4 in-width bits compared", {7'b0, f}, 8'h00);

        // R6 no tick
        live_time = base_time();
        repeat (4) @(negedge clk);
        flag_now(f); check("R6 no tick", {7'b0, f}, 8'h00);

        // R7 gating
        wr(4'h0, 8'h00); pulse_tick(); flag_now(f);
        check("R7 disabled", {7'b0, f}, 8'h00);
        wr(4'h0, 8'h0C); pulse_tick(); flag_now(f);
        check("R7 calibration", {7'b0, f}, 8'h00);

        // R11 timing
        wr(4'h0, 8'h08);
        @(negedge clk);
        tick = 1'b1;
        flag_now(f); check("R11 not early", {7'b0, f}, 8'h00);
        @(negedge clk);
        tick = 1'b0;
        flag_now(f); check("R11 after edge", {7'b0, f}, 8'h01);

        // R8 sticky
        lv = base_time(); lv[7:0] = 8'h00; live_time = lv;
        pulse_tick(); flag_now(f); check("R8 holds on miss", {7'b0, f}, 8'h01);
        wr(4'h0, 8'h48); flag_now(f); check("R8 write one keeps", {7'b0, f}, 8'h01);
        wr(4'h0, 8'h08); flag_now(f); check("R8 write zero clears", {7'b0, f}, 8'h00);

        // R9 set beats clear
        live_time = base_time();
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 4'h0; wr_data = 8'h08;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        flag_now(f); check("R9 set priority", {7'b0, f}, 8'h01);

        // R10 interrupt composition
        check("R10 osel off", {7'b0, alarm_irq}, 8'h00);
        wr(4'hE, 8'h80);
        check("R10 active", {7'b0, alarm_irq}, 8'h01);
        wr(4'h0, 8'h4C);
        check("R10 cal blocks", {7'b0, alarm_irq}, 8'h00);
        rd(4'h0, d); check("R10 flag kept", d, 8'h4C);
        wr(4'h0, 8'h48);
        check("R10 rearmed", {7'b0, alarm_irq}, 8'h01);
        wr(4'h0, 8'h40);
        check("R10 enable off", {7'b0, alarm_irq}, 8'h00);
        rd(4'h0, d); check("R10 flag with en off", d, 8'h40);
        wr(4'h0, 8'h08);
        check("R10 flag cleared", {7'b0, alarm_irq}, 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule